// File: doc/BRIEF.md
# Inclusive L2 Line Coherence Controller

This block tracks the coherence state of one line held in an inclusive, shared second-level cache bank. The bank serves N private first-level caches. Each cycle it may take one decoded event: a read, an instruction fetch, a write, an upgrade or a write-back from a first-level cache. It may also take an unblock or exclusive unblock from a requester, write-back data from an owner, fill data from memory, or an eviction or invalidation for the line. From these it keeps the line state, a one-hot sharer vector and the owner identifier.

Alongside each state update it emits single-cycle strobes for the outgoing messages. These are a memory fetch, a forward to the owner, an invalidate with its destination mask, data with its destination mask and an exclusive flag, and a write-back acknowledge with its destination. An event that the current state cannot take raises a recycle pulse and leaves all line state untouched, so the surrounding logic can present it again later.

When a first-level cache owns the line, the bank's own copy is taken as stale. A read to such a line is forwarded to the owner. The line then waits until both the requester's unblock and the owner's data have arrived, and it accepts them in either order.

Top module: `l2_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset, state_o is 0, sharers_o and owner_o are 0, perm_o is 0 and every strobe is low. state_o codes are: 0 IDLE, 1 SHRD, 2 DIRTY, 3 OWNED, 4 FILLX, 5 FILLS, 6 FILLW, 7 SHRD_XB, 8 DIRTY_XB, 9 OWNED_XB, 10 DNG_WAIT2, 11 DNG_WDATA, 12 DNG_WUNB.
- R2: In IDLE, a read (ev_kind 0) moves to FILLX, an instruction fetch (1) moves to FILLS and a write (2) moves to FILLW. Each of these raises fetch_o for one cycle. A read or fetch sets sharers_o to the requester alone. A write clears sharers_o and sets owner_o to the requester.
- R3: In FILLX or FILLS, another read or fetch adds the requester to sharers_o and moves to FILLS. A write or upgrade (3) in FILLX, FILLS or FILLW is recycled.
- R4: Fill data (ev_kind 8) has three outcomes. In FILLX it sends exclusive data (data_o and data_excl_o) to the sharer mask and moves to OWNED_XB. In FILLS it sends data to the sharer mask and moves to SHRD. In FILLW it sends data to the owner alone and moves to OWNED_XB.
- R5: In OWNED, a read or fetch raises fwd_o and moves to DNG_WAIT2. From DNG_WAIT2, an unblock (5) adds its sender to sharers_o and moves to DNG_WDATA, while owner data (7) moves to DNG_WUNB. Whichever of the two comes second completes the move to SHRD; the unblock sender is added when the unblock arrives.
- R6: An exclusive unblock (6) in SHRD_XB, DIRTY_XB or OWNED_XB moves to OWNED. It sets sharers_o to the sender alone and owner_o to the sender.
- R7: A write-back (4) from a current sharer in OWNED moves to DIRTY, clears sharers_o and acknowledges. A write-back in SHRD_XB, OWNED_XB or DNG_WAIT2 is recycled. In any other case it is only acknowledged (wback_ack_o, ack_dst_o = sender) and the line state does not change.
- R8: In DIRTY, a read sends exclusive data to the requester and moves to OWNED_XB. A fetch sends data, adds the requester and moves to SHRD. A write sends exclusive data and moves to DIRTY_XB.
- R9: In SHRD, a read or fetch sends data to the requester and adds it as a sharer. A write, or an upgrade from a non-sharer, sends exclusive data to the requester, invalidates all other sharers and moves to SHRD_XB. An upgrade from a sharer only invalidates the other sharers and moves to SHRD_XB.
- R10: The states SHRD_XB, DIRTY_XB, OWNED_XB and DNG_* recycle reads, fetches, writes, upgrades, evictions (9) and directory invalidations (10). Any event a state does not handle, including the unused codes 11 to 15, raises recycle_o alone and changes no line state.
- R11: An eviction or directory invalidation has three cases. In SHRD, DIRTY or OWNED it invalidates the whole sharer mask, clears it and moves to IDLE. In IDLE it does nothing. In FILLX, FILLS and FILLW it is recycled.
- R12: perm_o is 0 in IDLE, 1 (read-only) in SHRD, 2 (read-write) in DIRTY, 3 (stale) in OWNED and 4 (busy) in every other state.
- R13: Strobes are registered single-cycle pulses that change on the same edge as the state they go with. A cycle with ev_valid low produces no strobe and no state change. A write or upgrade in OWNED raises fwd_o and moves to OWNED_XB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 4 | Event code (see R2 to R11) |
| ev_src | input | IDW | Requester or sender identifier |
| state_o | output | 4 | Line state code |
| sharers_o | output | N | One-hot-per-cache sharer vector |
| owner_o | output | IDW | Owner identifier |
| perm_o | output | 3 | Access permission code |
| recycle_o | output | 1 | Event was not taken |
| fetch_o | output | 1 | Fetch from memory |
| fwd_o | output | 1 | Forward request to owner_o |
| inv_o | output | 1 | Invalidate the caches in inv_mask_o |
| inv_mask_o | output | N | Invalidate destinations |
| data_o | output | 1 | Send data to data_mask_o |
| data_excl_o | output | 1 | Data carries exclusive permission |
| data_mask_o | output | N | Data destinations |
| wback_ack_o | output | 1 | Write-back acknowledge |
| ack_dst_o | output | IDW | Acknowledge destination |

## Verification
The properties assume that ev_src always names an existing cache. They also assume that at most one event is presented per cycle, since the interface has only one event slot. With a power-of-two N every source value is legal, and the stimulus draws sources modulo N. Event codes are never restricted: the random phase draws all codes including unused ones, because every code/state pair has a defined outcome of handle or recycle. A directed walk runs first and passes through both unblock orders, all three fill kinds, the owner write-back, upgrades and evictions.

// File: rtl/l2cc_pkg.sv
// Shared types for the L2 line coherence controller.
// Assumes nothing beyond being compiled before the modules that import it.
package l2cc_pkg;

    // Line states; encodings are visible on state_o.
    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_SHRD      = 4'd1,
        ST_DIRTY     = 4'd2,
        ST_OWNED     = 4'd3,
        ST_FILLX     = 4'd4,
        ST_FILLS     = 4'd5,
        ST_FILLW     = 4'd6,
        ST_SHRD_XB   = 4'd7,
        ST_DIRTY_XB  = 4'd8,
        ST_OWNED_XB  = 4'd9,
        ST_DNG_WAIT2 = 4'd10,
        ST_DNG_WDATA = 4'd11,
        ST_DNG_WUNB  = 4'd12
    } line_state_e;

    // External event codes on ev_kind.
    typedef enum logic [3:0] {
        EV_RD      = 4'd0,
        EV_IFETCH  = 4'd1,
        EV_WR      = 4'd2,
        EV_UPG     = 4'd3,
        EV_WBACK   = 4'd4,
        EV_UNBLK   = 4'd5,
        EV_XUNBLK  = 4'd6,
        EV_WBDATA  = 4'd7,
        EV_MEMDATA = 4'd8,
        EV_EVICT   = 4'd9,
        EV_DIRINV  = 4'd10
    } ev_kind_e;

    // Classified operations after sharer-dependent decoding.
    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD,
        OP_IF,
        OP_WR,
        OP_UPG,
        OP_PUT_OWN,
        OP_PUT_OTHER,
        OP_UNBLK,
        OP_XUNBLK,
        OP_WBDATA,
        OP_MEMDATA,
        OP_DROP,
        OP_BAD
    } op_e;

    // Access permission codes on perm_o.
    typedef enum logic [2:0] {
        PERM_NONE  = 3'd0,
        PERM_RO    = 3'd1,
        PERM_RW    = 3'd2,
        PERM_STALE = 3'd3,
        PERM_BUSY  = 3'd4
    } perm_e;

endpackage

// File: rtl/l2_ev_classify.sv
// Event classifier: decodes the requester into a one-hot vector and turns
// the raw event code into an operation, resolving upgrade-versus-write and
// owner-versus-stale write-back from the current sharer vector.
// Assumes ev_src < N.
module l2_ev_classify
    import l2cc_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic              ev_valid,
    input  logic [3:0]        ev_kind,
    input  logic [IDW-1:0]    ev_src,
    input  line_state_e       state,
    input  logic [N-1:0]      sharers,
    output op_e               op,
    output logic [N-1:0]      src_1h
);

    logic src_is_sharer;

    // One comparator per cache builds the requester one-hot vector.
    for (genvar g = 0; g < N; g++) begin : g_src_dec
        assign src_1h[g] = (ev_src == IDW'(g));
    end

    assign src_is_sharer = |(src_1h & sharers);

    // Map raw code plus sharer test to an operation.
    always_comb begin
        op = OP_NONE;
        if (ev_valid) begin
            case (ev_kind)
                EV_RD:      op = OP_RD;
                EV_IFETCH:  op = OP_IF;
                EV_WR:      op = OP_WR;
                EV_UPG:     op = (state == ST_SHRD && src_is_sharer) ? OP_UPG : OP_WR;
                EV_WBACK:   op = src_is_sharer ? OP_PUT_OWN : OP_PUT_OTHER;
                EV_UNBLK:   op = OP_UNBLK;
                EV_XUNBLK:  op = OP_XUNBLK;
                EV_WBDATA:  op = OP_WBDATA;
                EV_MEMDATA: op = OP_MEMDATA;
                EV_EVICT,
                EV_DIRINV:  op = OP_DROP;
                default:    op = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/l2_line_next.sv
// Transition table: from the current line state, sharers, owner and the
// classified operation, computes the next line state and the message
// strobes. Purely combinational; anything unhandled becomes a recycle
// that leaves all line state as it was.
module l2_line_next
    import l2cc_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  line_state_e       state,
    input  logic [N-1:0]      sharers,
    input  logic [IDW-1:0]    owner,
    input  op_e               op,
    input  logic [N-1:0]      src_1h,
    input  logic [IDW-1:0]    src,
    output line_state_e       nx_state,
    output logic [N-1:0]      nx_sharers,
    output logic [IDW-1:0]    nx_owner,
    output logic              nx_recycle,
    output logic              nx_fetch,
    output logic              nx_fwd,
    output logic [N-1:0]      nx_inv_mask,
    output logic              nx_data,
    output logic              nx_excl,
    output logic [N-1:0]      nx_data_mask,
    output logic              nx_wback
);

    localparam logic [N-1:0] ONE = N'(1);

    logic [N-1:0] own_1h;
    logic         wait_blk;   // states that cannot take a write-back
    logic         any_blk;    // all blocking states

    assign own_1h   = ONE << owner;
    assign wait_blk = (state == ST_SHRD_XB) || (state == ST_OWNED_XB) ||
                      (state == ST_DNG_WAIT2);
    assign any_blk  = wait_blk || (state == ST_DIRTY_XB) ||
                      (state == ST_DNG_WDATA) || (state == ST_DNG_WUNB);

    // Per-operation next-state and strobe selection.
    always_comb begin
        nx_state     = state;
        nx_sharers   = sharers;
        nx_owner     = owner;
        nx_recycle   = 1'b0;
        nx_fetch     = 1'b0;
        nx_fwd       = 1'b0;
        nx_inv_mask  = '0;
        nx_data      = 1'b0;
        nx_excl      = 1'b0;
        nx_data_mask = '0;
        nx_wback     = 1'b0;

        case (op)
            OP_NONE: ;

            OP_RD, OP_IF: begin
                case (state)
                    ST_IDLE: begin
                        nx_sharers = src_1h;
                        nx_fetch   = 1'b1;
                        nx_state   = (op == OP_RD) ? ST_FILLX : ST_FILLS;
                    end
                    ST_FILLX, ST_FILLS: begin
                        nx_sharers = sharers | src_1h;
                        nx_state   = ST_FILLS;
                    end
                    ST_SHRD: begin
                        nx_data      = 1'b1;
                        nx_data_mask = src_1h;
                        nx_sharers   = sharers | src_1h;
                    end
                    ST_DIRTY: begin
                        nx_data      = 1'b1;
                        nx_data_mask = src_1h;
                        if (op == OP_RD) begin
                            nx_excl  = 1'b1;
                            nx_state = ST_OWNED_XB;
                        end else begin
                            nx_sharers = sharers | src_1h;
                            nx_state   = ST_SHRD;
                        end
                    end
                    ST_OWNED: begin
                        nx_fwd   = 1'b1;
                        nx_state = ST_DNG_WAIT2;
                    end
                    default: nx_recycle = 1'b1;
                endcase
            end

            OP_WR: begin
                case (state)
                    ST_IDLE: begin
                        nx_sharers = '0;
                        nx_owner   = src;
                        nx_fetch   = 1'b1;
                        nx_state   = ST_FILLW;
                    end
                    ST_SHRD: begin
                        nx_data      = 1'b1;
                        nx_excl      = 1'b1;
                        nx_data_mask = src_1h;
                        nx_inv_mask  = sharers & ~src_1h;
                        nx_state     = ST_SHRD_XB;
                    end
                    ST_DIRTY: begin
                        nx_data      = 1'b1;
                        nx_excl      = 1'b1;
                        nx_data_mask = src_1h;
                        nx_state     = ST_DIRTY_XB;
                    end
                    ST_OWNED: begin
                        nx_fwd   = 1'b1;
                        nx_state = ST_OWNED_XB;
                    end
                    default: nx_recycle = 1'b1;
                endcase
            end

            OP_UPG: begin
                // Only produced in SHRD by a current sharer.
                nx_inv_mask = sharers & ~src_1h;
                nx_state    = ST_SHRD_XB;
            end

            OP_PUT_OWN, OP_PUT_OTHER: begin
                if (op == OP_PUT_OWN && state == ST_OWNED) begin
                    nx_sharers = '0;
                    nx_wback   = 1'b1;
                    nx_state   = ST_DIRTY;
                end else if (wait_blk) begin
                    nx_recycle = 1'b1;
                end else begin
                    nx_wback = 1'b1;
                end
            end

            OP_UNBLK: begin
                case (state)
                    ST_DNG_WAIT2: begin
                        nx_sharers = sharers | src_1h;
                        nx_state   = ST_DNG_WDATA;
                    end
                    ST_DNG_WUNB: begin
                        nx_sharers = sharers | src_1h;
                        nx_state   = ST_SHRD;
                    end
                    default: nx_recycle = 1'b1;
                endcase
            end

            OP_XUNBLK: begin
                case (state)
                    ST_SHRD_XB, ST_DIRTY_XB, ST_OWNED_XB: begin
                        nx_sharers = src_1h;
                        nx_owner   = src;
                        nx_state   = ST_OWNED;
                    end
                    default: nx_recycle = 1'b1;
                endcase
            end

            OP_WBDATA: begin
                case (state)
                    ST_DNG_WAIT2: nx_state = ST_DNG_WUNB;
                    ST_DNG_WDATA: nx_state = ST_SHRD;
                    default:      nx_recycle = 1'b1;
                endcase
            end

            OP_MEMDATA: begin
                case (state)
                    ST_FILLX: begin
                        nx_data      = 1'b1;
                        nx_excl      = 1'b1;
                        nx_data_mask = sharers;
                        nx_state     = ST_OWNED_XB;
                    end
                    ST_FILLS: begin
                        nx_data      = 1'b1;
                        nx_data_mask = sharers;
                        nx_state     = ST_SHRD;
                    end
                    ST_FILLW: begin
                        nx_data      = 1'b1;
                        nx_data_mask = own_1h;
                        nx_state     = ST_OWNED_XB;
                    end
                    default: nx_recycle = 1'b1;
                endcase
            end

            OP_DROP: begin
                case (state)
                    ST_IDLE: ;
                    ST_SHRD, ST_DIRTY, ST_OWNED: begin
                        nx_inv_mask = sharers;
                        nx_sharers  = '0;
                        nx_state    = ST_IDLE;
                    end
                    default: nx_recycle = 1'b1;
                endcase
            end

            default: nx_recycle = 1'b1;
        endcase

        // Blocking states never take a new request, whatever the table says.
        if (any_blk && (op == OP_RD || op == OP_IF || op == OP_WR ||
                        op == OP_DROP)) begin
            nx_state     = state;
            nx_sharers   = sharers;
            nx_owner     = owner;
            nx_recycle   = 1'b1;
            nx_fetch     = 1'b0;
            nx_fwd       = 1'b0;
            nx_inv_mask  = '0;
            nx_data      = 1'b0;
            nx_excl      = 1'b0;
            nx_data_mask = '0;
        end
    end

endmodule

// File: rtl/l2_perm_map.sv
// Maps the line state to the access permission the data array may grant.
// Combinational; assumes a legal state code.
module l2_perm_map
    import l2cc_pkg::*;
(
    input  line_state_e state,
    output perm_e       perm
);

    // Stable states carry their own permission; all others are busy.
    always_comb begin
        case (state)
            ST_IDLE:  perm = PERM_NONE;
            ST_SHRD:  perm = PERM_RO;
            ST_DIRTY: perm = PERM_RW;
            ST_OWNED: perm = PERM_STALE;
            default:  perm = PERM_BUSY;
        endcase
    end

endmodule

// File: rtl/l2_line_ctrl.sv
// Top of the L2 line coherence controller. Takes one decoded event per
// cycle for a single line, registers the new state, sharers and owner, and
// registers the matching message strobes so that they pulse for exactly
// the cycle in which the new state first appears.
// Assumes ev_src < N and a synchronous active-low reset.
module l2_line_ctrl
    import l2cc_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [3:0]        ev_kind,
    input  logic [IDW-1:0]    ev_src,
    output logic [3:0]        state_o,
    output logic [N-1:0]      sharers_o,
    output logic [IDW-1:0]    owner_o,
    output logic [2:0]        perm_o,
    output logic              recycle_o,
    output logic              fetch_o,
    output logic              fwd_o,
    output logic              inv_o,
    output logic [N-1:0]      inv_mask_o,
    output logic              data_o,
    output logic              data_excl_o,
    output logic [N-1:0]      data_mask_o,
    output logic              wback_ack_o,
    output logic [IDW-1:0]    ack_dst_o
);

    line_state_e      state_q, nx_state;
    logic [N-1:0]     sharers_q, nx_sharers;
    logic [IDW-1:0]   owner_q, nx_owner;
    op_e              op;
    logic [N-1:0]     src_1h;
    logic             nx_recycle, nx_fetch, nx_fwd, nx_data, nx_excl, nx_wback;
    logic [N-1:0]     nx_inv_mask, nx_data_mask;
    perm_e            perm;

    l2_ev_classify #(.N(N), .IDW(IDW)) u_cls (
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .ev_src   (ev_src),
        .state    (state_q),
        .sharers  (sharers_q),
        .op       (op),
        .src_1h   (src_1h)
    );

    l2_line_next #(.N(N), .IDW(IDW)) u_nxt (
        .state        (state_q),
        .sharers      (sharers_q),
        .owner        (owner_q),
        .op           (op),
        .src_1h       (src_1h),
        .src          (ev_src),
        .nx_state     (nx_state),
        .nx_sharers   (nx_sharers),
        .nx_owner     (nx_owner),
        .nx_recycle   (nx_recycle),
        .nx_fetch     (nx_fetch),
        .nx_fwd       (nx_fwd),
        .nx_inv_mask  (nx_inv_mask),
        .nx_data      (nx_data),
        .nx_excl      (nx_excl),
        .nx_data_mask (nx_data_mask),
        .nx_wback     (nx_wback)
    );

    l2_perm_map u_perm (
        .state (state_q),
        .perm  (perm)
    );

    // Line state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sharers_q <= '0;
            owner_q   <= '0;
        end else begin
            state_q   <= nx_state;
            sharers_q <= nx_sharers;
            owner_q   <= nx_owner;
        end
    end

    // Message strobe registers, updated on the same edge as the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recycle_o   <= 1'b0;
            fetch_o     <= 1'b0;
            fwd_o       <= 1'b0;
            inv_o       <= 1'b0;
            inv_mask_o  <= '0;
            data_o      <= 1'b0;
            data_excl_o <= 1'b0;
            data_mask_o <= '0;
            wback_ack_o <= 1'b0;
            ack_dst_o   <= '0;
        end else begin
            recycle_o   <= nx_recycle;
            fetch_o     <= nx_fetch;
            fwd_o       <= nx_fwd;
            inv_o       <= |nx_inv_mask;
            inv_mask_o  <= nx_inv_mask;
            data_o      <= nx_data;
            data_excl_o <= nx_excl;
            data_mask_o <= nx_data_mask;
            wback_ack_o <= nx_wback;
            ack_dst_o   <= nx_wback ? ev_src : '0;
        end
    end

    assign state_o   = state_q;
    assign sharers_o = sharers_q;
    assign owner_o   = owner_q;
    assign perm_o    = perm;

endmodule

// File: rtl/l2_line_ctrl_chk.sv
// Property checker for l2_line_ctrl, attached by bind. Observes ports only.
module l2_line_ctrl_chk
    import l2cc_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [3:0]        state_o,
    input logic [N-1:0]      sharers_o,
    input logic [IDW-1:0]    owner_o,
    input logic [2:0]        perm_o,
    input logic              recycle_o,
    input logic              fetch_o,
    input logic              fwd_o,
    input logic              inv_o,
    input logic [N-1:0]      data_mask_o,
    input logic              data_o,
    input logic              data_excl_o,
    input logic              wback_ack_o
);

    localparam logic [N-1:0] ONE = N'(1);

    // R1
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE) |-> (sharers_o == '0));

    // R2
    fetch_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> ($past(state_o) == ST_IDLE) &&
                    (state_o == ST_FILLX || state_o == ST_FILLS || state_o == ST_FILLW));

    // R4
    excl_single_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_excl_o |-> data_o && ($countones(data_mask_o) == 1));

    // R5
    fwd_from_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_o |-> ($past(state_o) == ST_OWNED) &&
                  (state_o == ST_DNG_WAIT2 || state_o == ST_OWNED_XB));

    // R6
    owned_sole_sharer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OWNED) |-> (sharers_o == (ONE << owner_o)));

    // R10
    recycle_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recycle_o |-> $stable(state_o) && $stable(sharers_o) && $stable(owner_o));

    // R10
    recycle_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recycle_o |-> !(fetch_o || fwd_o || inv_o || data_o || wback_ack_o));

    // R12
    transient_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o > 4'd3) |-> (perm_o == PERM_BUSY));

    // R13
    idle_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> !(recycle_o || fetch_o || fwd_o || inv_o || data_o || wback_ack_o)
                      && $stable(state_o));

endmodule

bind l2_line_ctrl l2_line_ctrl_chk #(.N(N), .IDW(IDW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .state_o     (state_o),
    .sharers_o   (sharers_o),
    .owner_o     (owner_o),
    .perm_o      (perm_o),
    .recycle_o   (recycle_o),
    .fetch_o     (fetch_o),
    .fwd_o       (fwd_o),
    .inv_o       (inv_o),
    .data_mask_o (data_mask_o),
    .data_o      (data_o),
    .data_excl_o (data_excl_o),
    .wback_ack_o (wback_ack_o)
);

// File: tb/tb_l2_line_ctrl.sv
`timescale 1ns/1ps
module tb_l2_line_ctrl;

    localparam int NL  = 4;
    localparam int IDW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ev_valid;
    logic [3:0]      ev_kind;
    logic [IDW-1:0]  ev_src;
    logic [3:0]      state_o;
    logic [NL-1:0]   sharers_o, inv_mask_o, data_mask_o;
    logic [IDW-1:0]  owner_o, ack_dst_o;
    logic [2:0]      perm_o;
    logic            recycle_o, fetch_o, fwd_o, inv_o, data_o, data_excl_o, wback_ack_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    l2_line_ctrl #(.N(NL)) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_src(ev_src), .state_o(state_o), .sharers_o(sharers_o),
        .owner_o(owner_o), .perm_o(perm_o), .recycle_o(recycle_o),
        .fetch_o(fetch_o), .fwd_o(fwd_o), .inv_o(inv_o), .inv_mask_o(inv_mask_o),
        .data_o(data_o), .data_excl_o(data_excl_o), .data_mask_o(data_mask_o),
        .wback_ack_o(wback_ack_o), .ack_dst_o(ack_dst_o)
    );

    // Reference model state
    int        m_st;
    logic [3:0] m_sh;
    int        m_own;
    // Expected outputs
    int        e_st, e_own, e_ack;
    logic [3:0] e_sh, e_invm, e_dm;
    bit        e_rec, e_fetch, e_fwd, e_data, e_excl, e_wb;

    function automatic int perm_of(input int st);
        case (st)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            default: return 4;
        endcase
    endfunction

    // Behavioural reference: expected result of one event from the requirements.
    task automatic model(input bit v, input int k, input int s);
        logic [3:0] s1;
        int kk;
        s1 = 4'b0001 << s;
        e_st = m_st; e_sh = m_sh; e_own = m_own; e_ack = 0;
        e_invm = 0; e_dm = 0;
        {e_rec, e_fetch, e_fwd, e_data, e_excl, e_wb} = '0;
        if (v) begin
            kk = k;
            if (k == 3) kk = (m_st == 1 && m_sh[s]) ? 99 : 2;
            if (m_st >= 7 && (kk == 0 || kk == 1 || kk == 2 || kk == 99 || kk == 9 || kk == 10))
                kk = -1;
            case (kk)
                0, 1: case (m_st)
                    0: begin e_sh = s1; e_fetch = 1; e_st = (kk == 0) ? 4 : 5; end
                    4, 5: begin e_sh = m_sh | s1; e_st = 5; end
                    1: begin e_data = 1; e_dm = s1; e_sh = m_sh | s1; end
                    2: if (kk == 0) begin e_data = 1; e_excl = 1; e_dm = s1; e_st = 9; end
                       else begin e_data = 1; e_dm = s1; e_sh = m_sh | s1; e_st = 1; end
                    3: begin e_fwd = 1; e_st = 10; end
                    default: e_rec = 1;
                endcase
                2: case (m_st)
                    0: begin e_sh = 0; e_own = s; e_fetch = 1; e_st = 6; end
                    1: begin e_data = 1; e_excl = 1; e_dm = s1; e_invm = m_sh & ~s1; e_st = 7; end
                    2: begin e_data = 1; e_excl = 1; e_dm = s1; e_st = 8; end
                    3: begin e_fwd = 1; e_st = 9; end
                    default: e_rec = 1;
                endcase
                99: begin e_invm = m_sh & ~s1; e_st = 7; end
                4: if (m_st == 3 && m_sh[s]) begin e_st = 2; e_sh = 0; e_wb = 1; e_ack = s; end
                   else if (m_st == 7 || m_st == 9 || m_st == 10) e_rec = 1;
                   else begin e_wb = 1; e_ack = s; end
                5: if (m_st == 10) begin e_sh = m_sh | s1; e_st = 11; end
                   else if (m_st == 12) begin e_sh = m_sh | s1; e_st = 1; end
                   else e_rec = 1;
                6: if (m_st >= 7 && m_st <= 9) begin e_sh = s1; e_own = s; e_st = 3; end
                   else e_rec = 1;
                7: if (m_st == 10) e_st = 12;
                   else if (m_st == 11) e_st = 1;
                   else e_rec = 1;
                8: case (m_st)
                    4: begin e_data = 1; e_excl = 1; e_dm = m_sh; e_st = 9; end
                    5: begin e_data = 1; e_dm = m_sh; e_st = 1; end
                    6: begin e_data = 1; e_dm = 4'b0001 << m_own; e_st = 9; end
                    default: e_rec = 1;
                endcase
                9, 10: case (m_st)
                    0: ;
                    1, 2, 3: begin e_invm = m_sh; e_sh = 0; e_st = 0; end
                    default: e_rec = 1;
                endcase
                default: e_rec = 1;
            endcase
        end
    endtask

    function automatic logic [29:0] pack_exp();
        return {4'(e_st), e_sh, 2'(e_own), 3'(perm_of(e_st)), e_rec, e_fetch, e_fwd,
                (|e_invm), e_invm, e_data, e_excl, e_dm, e_wb, 2'(e_ack)};
    endfunction

    function automatic logic [29:0] pack_act();
        return {state_o, sharers_o, owner_o, perm_o, recycle_o, fetch_o, fwd_o,
                inv_o, inv_mask_o, data_o, data_excl_o, data_mask_o, wback_ack_o, ack_dst_o};
    endfunction

    // One event: drive at a falling edge, compare at the next falling edge.
    task automatic step(input bit v, input int k, input int s, input string tag);
        ev_valid = v;
        ev_kind  = 4'(k);
        ev_src   = IDW'(s);
        model(v, k, s);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pack_act() !== pack_exp()) begin
            errors++;
            $display("FAIL %s: kind=%0d src=%0d actual=%h expected=%h", tag, k, s,
                     pack_act(), pack_exp());
        end
        m_st = e_st; m_sh = e_sh; m_own = e_own;
        ev_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ev_valid = 0; ev_kind = 0; ev_src = 0;
        m_st = 0; m_sh = 0; m_own = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        model(0, 0, 0);
        checks++;
        if (pack_act() !== pack_exp()) begin
            errors++;
            $display("FAIL R1: actual=%h expected=%h", pack_act(), pack_exp());
        end
        step(1, 0, 1, "R2");    // idle read -> FILLX
        step(1, 2, 2, "R3");    // write recycled in fill
        step(1, 1, 3, "R3");    // extra reader -> FILLS
        step(1, 8, 0, "R4");    // shared fill to both readers
        step(1, 0, 0, "R9");    // shared read
        step(1, 2, 1, "R9");    // write with invalidates
        step(1, 0, 2, "R10");   // blocked read
        step(1, 9, 0, "R10");   // blocked eviction
        step(1, 6, 1, "R6");    // exclusive unblock
        step(1, 0, 3, "R5");    // forward read
        step(1, 7, 0, "R5");    // data first
        step(1, 5, 3, "R5");    // then unblock
        step(1, 9, 0, "R11");   // eviction from SHRD
        step(1, 10, 0, "R11");  // dir-inv in IDLE
        step(1, 2, 2, "R2");    // idle write
        step(1, 0, 1, "R10");   // read in FILLW
        step(1, 8, 0, "R4");    // fill to writer
        step(1, 6, 2, "R6");
        step(1, 1, 0, "R5");    // forward fetch
        step(1, 5, 0, "R5");    // unblock first
        step(1, 7, 0, "R5");    // then data
        step(1, 9, 0, "R11");
        step(1, 2, 3, "R2");
        step(1, 8, 0, "R4");
        step(1, 6, 3, "R6");
        step(1, 4, 0, "R7");    // stale write-back: ack only
        step(1, 4, 3, "R7");    // owner write-back -> DIRTY
        step(1, 0, 1, "R8");    // dirty read
        step(1, 6, 1, "R6");
        step(1, 4, 1, "R7");
        step(1, 2, 2, "R8");    // dirty write
        step(1, 6, 2, "R6");
        step(1, 4, 2, "R7");
        step(1, 1, 2, "R8");    // dirty fetch -> SHRD
        step(1, 3, 1, "R9");    // upgrade from non-sharer
        step(1, 6, 1, "R6");
        step(1, 9, 0, "R11");
        step(1, 1, 0, "R2");
        step(1, 8, 0, "R4");
        step(1, 1, 2, "R9");
        step(1, 3, 0, "R9");    // upgrade from sharer
        step(1, 4, 3, "R7");    // write-back recycled in SHRD_XB
        step(1, 6, 0, "R6");
        step(1, 2, 1, "R13");   // owned write -> OWNED_XB
        step(0, 0, 0, "R13");   // idle cycle
        step(1, 8, 0, "R10");   // fill data unexpected
        step(1, 13, 2, "R10");  // unused code
        step(1, 6, 1, "R6");
        for (int i = 0; i < 1500; i++)
            step(($urandom % 8) != 0, int'($urandom % 16), int'($urandom % NL), "R12");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule